// File: doc/BRIEF.md
# Chip-Select Protocol Lock

A dual-protocol serial peripheral shares its chip-select pin between two roles. While no protocol has been chosen, the I2C front end owns the bus. The host picks SPI by toggling chip-select. This block samples that pin in the system clock domain and counts its low-to-high transitions. The third transition switches the device into SPI mode for good.

The block feeds three things to the rest of the chip:

- a mode flag that steers which protocol front end is active;
- a per-cycle transfer-active indication while in SPI mode;
- a read-only status byte for the register file.

A software reset input reaches the block but has no effect on it. Only the power-on reset returns the device to I2C.

Internally the raw pin passes through a synchronizer and a rising-edge detector into a two-state machine.

- `ST_I2C_LISTEN` is entered on power-on reset. In this state the machine counts rising edges.
- On the rising edge that brings the count to the lock threshold, the transition **LOCK** moves it to `ST_SPI_LOCKED`.
- `ST_SPI_LOCKED` has a single transition, **HOLD**, back to itself. It has no way out except power-on reset.
- In `ST_I2C_LISTEN`, a rising edge below the threshold takes the transition **COUNT**. It increments the counter and keeps the state.

Top module: `serial_mode_lock`

## Requirements
- R1: The third rising edge of `cs_n_pin` after power-on reset sets `spi_mode` to 1. If the pin is driven high just before clock edge k, `spi_mode` reads 1 after edge k+2 and still 0 after edge k+1.
- R2: Only low-to-high transitions count. The result is the same whether the pin is low or high at power-on reset. A level held at reset, or falling edges alone, never count. Zero, one or two rising edges leave `spi_mode` at 0.
- R3: Once `spi_mode` is 1, it stays 1 for as long as `por_n` stays high, whatever `cs_n_pin` does, including further rising edges.
- R4: `sw_rst` has no effect. It neither clears a lock nor discards rising edges already counted. For example, two edges, then `sw_rst`, then one edge still locks.
- R5: Reading address 0x7F on `reg_addr` returns the lock flag in `reg_rdata` bit 0: 1 when `spi_mode` is 1, otherwise 0.
- R6: `reg_rdata` bits 7 to 1 always read 0, and every address other than 0x7F reads 0x00.
- R7: In SPI mode, `spi_xfer_active` is 1 exactly while the synchronized chip-select is low. After a pin change just before edge k, it follows after edge k+1.
- R8: Until the lock occurs, `spi_mode` is 0 (I2C) and `spi_xfer_active` stays 0 even while `cs_n_pin` is low.
- R9: Driving `por_n` low returns the block to I2C: `spi_mode` reads 0, the status bit reads 0, and the edge count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low; the only way to clear the lock |
| sw_rst | input | 1 | Software reset request; deliberately ignored by this block |
| cs_n_pin | input | 1 | Raw chip-select pin, asynchronous to `clk`, low = selected |
| reg_addr | input | 8 | Register file read address |
| reg_rdata | output | 8 | Read data; lock flag in bit 0 at address 0x7F |
| spi_mode | output | 1 | 1 = SPI front end active, 0 = I2C front end active |
| spi_xfer_active | output | 1 | 1 while in SPI mode with chip-select asserted low |

## Verification
The edge-count function is swept over zero to five chip-select pulses, from both a low and a high starting level. This separates a design that counts rising edges from one that counts any transition or the initial level. A cycle-exact probe of the third edge pins down the synchronizer plus detector latency.

Software-reset pulses are placed between the second and third edges and again after the lock, to show that neither the count nor the lock is touched. A full sweep of the 256 read addresses in both modes shows the status bit at 0x7F alone. Chip-select is toggled before and after the lock to separate the transfer indication from the mode flag.

// File: rtl/sml_pkg.sv
package sml_pkg;

    // Protocol selection states
    typedef enum logic [0:0] {
        ST_I2C_LISTEN = 1'b0,
        ST_SPI_LOCKED = 1'b1
    } sml_state_e;

    localparam logic [7:0] SML_STATUS_ADDR = 8'h7F;

endpackage

// File: rtl/sml_sync.sv
module sml_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= RST_VAL;
                    else        chain_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= RST_VAL;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sml_rise_det.sv
module sml_rise_det #(
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);

    logic level_d;

    // History starts at the idle level so a high pin at reset is no edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_d <= IDLE_LVL;
        else        level_d <= level;
    end

    assign rise = level & ~level_d;

endmodule

// File: rtl/sml_lock_fsm.sv
module sml_lock_fsm
    import sml_pkg::*;
#(
    parameter int unsigned LOCK_EDGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    output logic locked
);

    localparam int unsigned CNT_W = $clog2(LOCK_EDGES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_EDGES - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(LOCK_EDGES);

    sml_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register: cleared only by power-on reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_I2C_LISTEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions: COUNT, LOCK, HOLD
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_I2C_LISTEN: begin
                if (rise) begin
                    if (cnt_q == CNT_LAST) begin
                        state_d = ST_SPI_LOCKED;
                        cnt_d   = CNT_SAT;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_SPI_LOCKED: begin
                state_d = ST_SPI_LOCKED;
                cnt_d   = CNT_SAT;
            end
            default: begin
                state_d = ST_I2C_LISTEN;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_SPI_LOCKED: locked = 1'b1;
            default:       locked = 1'b0;
        endcase
    end

endmodule

// File: rtl/sml_status_rd.sv
module sml_status_rd #(
    parameter int unsigned       ADDR_W      = 8,
    parameter int unsigned       DATA_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(8'h7F)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              lock_flag,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (addr == STATUS_ADDR) rdata[0] = lock_flag;
    end

endmodule

// File: rtl/serial_mode_lock.sv
module serial_mode_lock #(
    parameter int unsigned       SYNC_STAGES = 2,
    parameter int unsigned       LOCK_EDGES  = 3,
    parameter int unsigned       ADDR_W      = 8,
    parameter int unsigned       DATA_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(sml_pkg::SML_STATUS_ADDR)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sw_rst,
    input  logic              cs_n_pin,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              spi_mode,
    output logic              spi_xfer_active
);

    logic cs_n_sync;
    logic cs_rise;
    logic lock_flag;

    // Software reset reaches this block but must leave the lock alone
    logic unused_sw_rst;
    assign unused_sw_rst = sw_rst;

    sml_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (por_n),
        .d_async (cs_n_pin),
        .q_sync  (cs_n_sync)
    );

    sml_rise_det #(
        .IDLE_LVL (1'b1)
    ) u_rise (
        .clk   (clk),
        .rst_n (por_n),
        .level (cs_n_sync),
        .rise  (cs_rise)
    );

    sml_lock_fsm #(
        .LOCK_EDGES (LOCK_EDGES)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (por_n),
        .rise   (cs_rise),
        .locked (lock_flag)
    );

    sml_status_rd #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .STATUS_ADDR (STATUS_ADDR)
    ) u_status (
        .addr      (reg_addr),
        .lock_flag (lock_flag),
        .rdata     (reg_rdata)
    );

    assign spi_mode        = lock_flag;
    assign spi_xfer_active = lock_flag & ~cs_n_sync;

endmodule

// File: rtl/sml_checker.sv
module sml_checker #(
    parameter int unsigned       ADDR_W      = 8,
    parameter int unsigned       DATA_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(8'h7F)
) (
    input logic              clk,
    input logic              por_n,
    input logic              sw_rst,
    input logic              cs_n_pin,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              spi_mode,
    input logic              spi_xfer_active
);

    // R1: a lock is preceded by the pin being high three sampled cycles earlier
    p_lock_after_rise_r1: assert property (@(posedge clk) disable iff (!por_n)
        $rose(spi_mode) |-> $past(cs_n_pin, 3));

    // R3: the lock never drops while power stays on
    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!por_n)
        spi_mode |=> spi_mode);

    // R4: software reset leaves a lock in place
    p_swrst_no_clear_r4: assert property (@(posedge clk) disable iff (!por_n)
        (spi_mode && sw_rst) |=> spi_mode);

    // R5: status bit at the status address mirrors the mode
    p_status_bit_r5: assert property (@(posedge clk) disable iff (!por_n)
        (reg_addr == STATUS_ADDR) |-> (reg_rdata[0] == spi_mode));

    // R6: upper bits and other addresses read zero
    p_upper_zero_r6: assert property (@(posedge clk) disable iff (!por_n)
        (reg_rdata[DATA_W-1:1] == '0) && ((reg_addr != STATUS_ADDR) -> (reg_rdata == '0)));

    // R7/R8: a transfer is only flagged in SPI mode
    p_xfer_needs_spi_r8: assert property (@(posedge clk) disable iff (!por_n)
        spi_xfer_active |-> spi_mode);

endmodule

bind serial_mode_lock sml_checker #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .STATUS_ADDR (STATUS_ADDR)
) u_sml_checker (.*);

// File: tb/tb_serial_mode_lock.sv
module tb_serial_mode_lock;

    logic       clk = 1'b0;
    logic       por_n;
    logic       sw_rst;
    logic       cs_n_pin;
    logic [7:0] reg_addr;
    logic [7:0] reg_rdata;
    logic       spi_mode;
    logic       spi_xfer_active;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    serial_mode_lock dut (
        .clk             (clk),
        .por_n           (por_n),
        .sw_rst          (sw_rst),
        .cs_n_pin        (cs_n_pin),
        .reg_addr        (reg_addr),
        .reg_rdata       (reg_rdata),
        .spi_mode        (spi_mode),
        .spi_xfer_active (spi_xfer_active)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic power_on(input logic start_lvl);
        @(negedge clk);
        por_n    = 1'b0;
        cs_n_pin = start_lvl;
        wait_n(3);
        por_n = 1'b1;
        wait_n(4);
    endtask

    task automatic pulse_cs();
        cs_n_pin = 1'b0;
        wait_n(4);
        cs_n_pin = 1'b1;
        wait_n(4);
    endtask

    task automatic read_status(input string req, input logic exp_lock);
        reg_addr = 8'h7F;
        #1;
        chk(req, reg_rdata, {7'b0, exp_lock});
    endtask

    initial begin
        por_n    = 1'b0;
        sw_rst   = 1'b0;
        cs_n_pin = 1'b1;
        reg_addr = 8'h00;

        // Reset state (R8, R9)
        power_on(1'b1);
        chk("R8 reset mode", {7'b0, spi_mode}, 8'h00);
        chk("R8 reset xfer", {7'b0, spi_xfer_active}, 8'h00);
        read_status("R9 reset status", 1'b0);

        // R1/R2 sweep: pulse count and starting level
        for (int st = 0; st < 2; st++) begin
            for (int n = 0; n < 6; n++) begin
                power_on(st[0]);
                for (int p = 0; p < n; p++) pulse_cs();
                chk((n >= 3) ? "R1 sweep mode" : "R2 sweep mode",
                    {7'b0, spi_mode}, {7'b0, (n >= 3)});
                read_status("R5 sweep status", (n >= 3));
            end
        end

        // R2: held low from reset, then falling edges only
        power_on(1'b0);
        wait_n(20);
        chk("R2 held low", {7'b0, spi_mode}, 8'h00);
        chk("R8 low before lock xfer", {7'b0, spi_xfer_active}, 8'h00);

        // R1 exact latency of the third edge
        power_on(1'b1);
        pulse_cs();
        pulse_cs();
        cs_n_pin = 1'b0;
        wait_n(4);
        cs_n_pin = 1'b1;
        @(negedge clk);
        chk("R1 latency e0", {7'b0, spi_mode}, 8'h00);
        @(negedge clk);
        chk("R1 latency e1", {7'b0, spi_mode}, 8'h00);
        @(negedge clk);
        chk("R1 latency e2", {7'b0, spi_mode}, 8'h01);

        // R7 transfer indication timing
        wait_n(3);
        chk("R7 idle xfer", {7'b0, spi_xfer_active}, 8'h00);
        cs_n_pin = 1'b0;
        @(negedge clk);
        chk("R7 xfer e0", {7'b0, spi_xfer_active}, 8'h00);
        @(negedge clk);
        chk("R7 xfer e1", {7'b0, spi_xfer_active}, 8'h01);
        cs_n_pin = 1'b1;
        wait_n(3);
        chk("R7 xfer end", {7'b0, spi_xfer_active}, 8'h00);

        // R3: many more edges keep the lock
        for (int p = 0; p < 5; p++) pulse_cs();
        chk("R3 sticky", {7'b0, spi_mode}, 8'h01);

        // R4: software reset while locked
        sw_rst = 1'b1;
        wait_n(5);
        sw_rst = 1'b0;
        wait_n(3);
        chk("R4 swrst locked", {7'b0, spi_mode}, 8'h01);
        read_status("R4 swrst status", 1'b1);

        // R5/R6 address sweep in locked mode
        for (int a = 0; a < 256; a++) begin
            reg_addr = a[7:0];
            #1;
            chk((a == 127) ? "R5 addr sweep" : "R6 addr sweep",
                reg_rdata, (a == 127) ? 8'h01 : 8'h00);
        end

        // R9: power-on reset unlocks
        power_on(1'b1);
        chk("R9 after por", {7'b0, spi_mode}, 8'h00);
        read_status("R9 status after por", 1'b0);
        pulse_cs();
        pulse_cs();
        chk("R9 count restarted", {7'b0, spi_mode}, 8'h00);

        // R4: software reset between second and third edge keeps the count
        @(negedge clk);
        sw_rst = 1'b1;
        wait_n(5);
        sw_rst = 1'b0;
        wait_n(2);
        chk("R4 swrst mid count", {7'b0, spi_mode}, 8'h00);
        pulse_cs();
        chk("R4 lock after swrst", {7'b0, spi_mode}, 8'h01);

        // R6 address sweep in I2C mode
        power_on(1'b1);
        for (int a = 0; a < 256; a++) begin
            reg_addr = a[7:0];
            #1;
            chk("R6 i2c addr sweep", reg_rdata, 8'h00);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule